// File: doc/BRIEF.md
# Status LED Driver with Stretched Activity and Lamp Test

This block turns the status of a 10/100 Ethernet port into drive levels for a small bank of indicator LEDs. Each LED has its own 4-bit mode field, which picks the status that LED shows. Two of the status inputs are levels: the line speed and the link state. These are shown as they are, with one register stage of delay. The other three inputs are activity signals: transmit, receive and collision. Their pulses can be as short as one clock, so each of these sources goes through a pulse stretcher that holds the indication long enough for the eye to see it.

Right after reset is released, every LED is lit for a fixed lamp-test period, whatever mode it is set to. The LEDs also stay lit while reset is held. Lamp-test length and stretch length are both parameters counted in clock cycles. The defaults give about one second of lamp test and about a tenth of a second of stretch at a 25 MHz clock. Outputs are active high; pad polarity is handled outside this block.

Top module: `phy_led_ctrl`

## Requirements
- R1: With mode code 4'b0000 (speed), an LED output equals the value `speed_i` had at the previous rising clock edge.
- R2: With mode code 4'b0001 (transmit), the LED shows the stretched form of `tx_i`.
- R3: With mode code 4'b0010 (receive), the LED shows the stretched form of `rx_i`.
- R4: With mode code 4'b0011 (collision), the LED shows the stretched form of `col_i`.
- R5: With mode code 4'b0100 (link), an LED output equals the value `link_i` had at the previous rising clock edge.
- R6: Any mode code from 4'b0101 to 4'b1111 turns the LED off.
- R7: While `rst_n` is low, all LEDs are on. After `rst_n` goes high, all LEDs stay on for the first LAMP_CYC rising edges, whatever the modes and inputs are.
- R8: A stretched source becomes active at the edge where its input is first sampled high after being sampled low. It stays active for exactly STRETCH_CYC cycles. Holding the input high does not make this longer.
- R9: A new rising edge on an activity input while that source is still active starts a full STRETCH_CYC window again, counted from the new edge.
- R10: LED i takes its mode from bits [4*i+3:4*i] of `led_mode_i`. The LEDs are independent, several LEDs may show the same source, and a mode change takes effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| led_mode_i | input | 4*NUM_LEDS | Packed per-LED mode fields, LED 0 in the low nibble |
| speed_i | input | 1 | Speed status level (1 = fast mode) |
| tx_i | input | 1 | Transmit activity |
| rx_i | input | 1 | Receive activity |
| col_i | input | 1 | Collision activity |
| link_i | input | 1 | Link status level |
| led_o | output | NUM_LEDS | LED drive, active high |

## Verification
The lamp test and the activity stretchers can be busy in the same cycle. A transmit, receive or collision edge that arrives during the last few lamp-test cycles starts a window that outlasts the lamp test. The bench provokes this by driving random activity all through the lamp period, with stretched modes selected. The LED must stay lit without a gap across the lamp-test boundary and must then go dark exactly STRETCH_CYC cycles after the last rising edge. A second overlap is a retrigger that lands on the edge where a window would end. This is provoked by pulses spaced exactly STRETCH_CYC apart, and the bench judges both cases against its own per-source model of cycles since the last edge.

// File: rtl/phy_led_pkg.sv
package phy_led_pkg;
  localparam int MODE_W  = 4;
  localparam int NUM_ACT = 3; // stretched sources: 0 transmit, 1 receive, 2 collision

  typedef enum logic [MODE_W-1:0] {
    LM_SPEED = 4'd0,
    LM_TX    = 4'd1,
    LM_RX    = 4'd2,
    LM_COL   = 4'd3,
    LM_LINK  = 4'd4
  } led_mode_e;

  typedef struct packed {
    logic               speed;
    logic               link;
    logic [NUM_ACT-1:0] act;
  } led_src_t;
endpackage

// File: rtl/led_lamp_test.sv
module led_lamp_test #(
  parameter int LAMP_CYC = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic lamp_o
);
  localparam int CW = $clog2(LAMP_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= CW'(LAMP_CYC);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign lamp_o = (cnt_q != '0);
endmodule

// File: rtl/led_pulse_stretch.sv
module led_pulse_stretch #(
  parameter int STRETCH_CYC = 2_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_i,
  output logic active_o
);
  localparam int CW = $clog2(STRETCH_CYC) + 1;
  localparam logic [CW-1:0] RELOAD = CW'(STRETCH_CYC - 1);

  logic          ev_q;
  logic [CW-1:0] cnt_q;
  logic          rise;

  assign rise = ev_i & ~ev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      ev_q <= ev_i;
      if (rise)               cnt_q <= RELOAD;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end
  end

  // active in the edge cycle itself and while the window is still counting
  assign active_o = rise | (cnt_q != '0);
endmodule

// File: rtl/led_src_mux.sv
module led_src_mux
  import phy_led_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  led_src_t          src_i,
  output logic              on_o
);
  always_comb begin
    case (mode_i)
      LM_SPEED: on_o = src_i.speed;
      LM_TX:    on_o = src_i.act[0];
      LM_RX:    on_o = src_i.act[1];
      LM_COL:   on_o = src_i.act[2];
      LM_LINK:  on_o = src_i.link;
      default:  on_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/phy_led_ctrl.sv
module phy_led_ctrl
  import phy_led_pkg::*;
#(
  parameter int NUM_LEDS    = 3,
  parameter int LAMP_CYC    = 25_000_000,
  parameter int STRETCH_CYC = 2_500_000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_LEDS*MODE_W-1:0] led_mode_i,
  input  logic                       speed_i,
  input  logic                       tx_i,
  input  logic                       rx_i,
  input  logic                       col_i,
  input  logic                       link_i,
  output logic [NUM_LEDS-1:0]        led_o
);
  logic               lamp;
  logic [NUM_ACT-1:0] act_raw;
  logic [NUM_ACT-1:0] act_str;
  led_src_t           src;

  assign act_raw = {col_i, rx_i, tx_i};

  led_lamp_test #(.LAMP_CYC(LAMP_CYC)) u_lamp (
    .clk(clk), .rst_n(rst_n), .lamp_o(lamp)
  );

  for (genvar s = 0; s < NUM_ACT; s++) begin : g_str
    led_pulse_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_str (
      .clk(clk), .rst_n(rst_n), .ev_i(act_raw[s]), .active_o(act_str[s])
    );
  end

  assign src.speed = speed_i;
  assign src.link  = link_i;
  assign src.act   = act_str;

  for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
    logic sel_on;
    led_src_mux u_mux (
      .mode_i(led_mode_i[i*MODE_W +: MODE_W]),
      .src_i (src),
      .on_o  (sel_on)
    );
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) led_o[i] <= 1'b1;
      else        led_o[i] <= lamp | sel_on;
    end
  end
endmodule

// File: rtl/phy_led_chk.sv
module phy_led_chk #(
  parameter int NUM_LEDS    = 3,
  parameter int LAMP_CYC    = 25_000_000,
  parameter int STRETCH_CYC = 2_500_000
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_LEDS*4-1:0] led_mode_i,
  input logic                  speed_i,
  input logic                  tx_i,
  input logic                  rx_i,
  input logic                  col_i,
  input logic                  link_i,
  input logic [NUM_LEDS-1:0]   led_o
);
  localparam int EW = $clog2(LAMP_CYC + 3) + 1;
  localparam logic [EW-1:0] SAT = EW'(LAMP_CYC + 2);
  logic [EW-1:0] edges_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           edges_q <= '0;
    else if (edges_q < SAT) edges_q <= edges_q + 1'b1;
  end

  logic normal;
  assign normal = (edges_q == SAT);

  // R7: every LED lit through the lamp-test window
  a_r7_lamp_all_on: assert property (@(posedge clk) disable iff (!rst_n)
    (edges_q <= EW'(LAMP_CYC)) |-> (led_o == '1));

  for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led_chk
    // R1: speed mode follows the level with one register of delay
    a_r1_speed_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (normal && $past(led_mode_i[i*4 +: 4]) == 4'd0) |-> (led_o[i] == $past(speed_i)));
    // R5: link mode follows the level with one register of delay
    a_r5_link_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (normal && $past(led_mode_i[i*4 +: 4]) == 4'd4) |-> (led_o[i] == $past(link_i)));
    // R6: codes above 4 keep the LED dark
    a_r6_undef_off: assert property (@(posedge clk) disable iff (!rst_n)
      (normal && $past(led_mode_i[i*4 +: 4]) > 4'd4) |-> !led_o[i]);
    // R2: a fresh transmit edge lights a transmit-mode LED at once
    a_r2_tx_edge_on: assert property (@(posedge clk) disable iff (!rst_n)
      (normal && $past(led_mode_i[i*4 +: 4]) == 4'd1 && $past(tx_i) && !$past(tx_i, 2))
      |-> led_o[i]);
    // R3: same for receive
    a_r3_rx_edge_on: assert property (@(posedge clk) disable iff (!rst_n)
      (normal && $past(led_mode_i[i*4 +: 4]) == 4'd2 && $past(rx_i) && !$past(rx_i, 2))
      |-> led_o[i]);
    // R4: same for collision
    a_r4_col_edge_on: assert property (@(posedge clk) disable iff (!rst_n)
      (normal && $past(led_mode_i[i*4 +: 4]) == 4'd3 && $past(col_i) && !$past(col_i, 2))
      |-> led_o[i]);
  end
endmodule

bind phy_led_ctrl phy_led_chk #(
  .NUM_LEDS(NUM_LEDS), .LAMP_CYC(LAMP_CYC), .STRETCH_CYC(STRETCH_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .led_mode_i(led_mode_i), .speed_i(speed_i),
  .tx_i(tx_i), .rx_i(rx_i), .col_i(col_i), .link_i(link_i), .led_o(led_o)
);

// File: tb/sim_phy_led_ctrl.sv
module sim_phy_led_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NL   = 3;
  localparam int LAMP = 12;
  localparam int STR  = 5;
  localparam int BIG  = 1000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL*4-1:0] mode = '0;
  logic speed = 0, tx = 0, rx = 0, col = 0, link = 0;
  logic [NL-1:0] led;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string phase = "R7 reset";

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_led_ctrl #(.NUM_LEDS(NL), .LAMP_CYC(LAMP), .STRETCH_CYC(STR)) u0 (
    .clk(clk), .rst_n(rst_n), .led_mode_i(mode), .speed_i(speed),
    .tx_i(tx), .rx_i(rx), .col_i(col), .link_i(link), .led_o(led)
  );

  // independent reference: edges since reset, cycles since each source's last rising edge
  int n_edges;
  int age [3];
  logic prev [3];
  logic [NL-1:0] exp_led;

  function automatic logic pick(input logic [3:0] m);
    case (m)
      4'd0: return speed;        // R1
      4'd1: return age[0] < STR; // R2
      4'd2: return age[1] < STR; // R3
      4'd3: return age[2] < STR; // R4
      4'd4: return link;         // R5
      default: return 1'b0;      // R6
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_edges = 0;
      for (int s = 0; s < 3; s++) begin age[s] = BIG; prev[s] = 1'b0; end
      exp_led = '1;
    end else begin
      logic cur [3];
      cur[0] = tx; cur[1] = rx; cur[2] = col;
      n_edges++;
      for (int s = 0; s < 3; s++) begin
        if (cur[s] && !prev[s]) age[s] = 0;       // R8/R9 restart on edge
        else if (age[s] < BIG)  age[s]++;
        prev[s] = cur[s];
      end
      for (int i = 0; i < NL; i++)
        exp_led[i] = (n_edges <= LAMP) ? 1'b1 : pick(mode[i*4 +: 4]);
    end
  end

  task automatic check_now();
    checks++;
    if (led !== exp_led) begin
      errors++;
      $display("FAIL %s modes=%h actual=%b expected=%b", phase, mode, led, exp_led);
    end
  endtask

  task automatic step(input logic [NL*4-1:0] m, input logic s, t, r, c, l);
    @(negedge clk);
    check_now();
    mode = m; speed = s; tx = t; rx = r; col = c; link = l;
  endtask

  task automatic idle(input int n, input logic [NL*4-1:0] m);
    for (int k = 0; k < n; k++) step(m, speed, 0, 0, 0, link);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    // R7: lit while reset held
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      checks++;
      if (led !== '1) begin errors++; $display("FAIL R7 reset actual=%b expected=111", led); end
    end
    rst_n = 1'b1;
    // R7 lamp window with random activity, stretched modes selected; overlap at lamp end
    phase = "R7 lamp overlap";
    for (int k = 0; k < LAMP + 4; k++)
      step(12'h321, $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1),
           (k == LAMP - 2), $urandom_range(0,1));
    idle(STR + 2, 12'h321);
    // R2 R8: single transmit pulse, exactly STR cycles lit
    phase = "R2 R8 tx single pulse";
    step(12'h321, 0, 1, 0, 0, 0);
    idle(STR + 3, 12'h321);
    // R3 R8: held receive level does not lengthen the window
    phase = "R3 R8 rx held high";
    for (int k = 0; k < 3*STR; k++) step(12'h321, 0, 0, 1, 0, 0);
    idle(STR + 2, 12'h321);
    // R4 R9: collision retrigger, including an edge landing exactly at window end
    phase = "R4 R9 col retrigger";
    step(12'h321, 0, 0, 0, 1, 0); step(12'h321, 0, 0, 0, 0, 0);
    step(12'h321, 0, 0, 0, 1, 0);
    for (int k = 0; k < STR - 1; k++) step(12'h321, 0, 0, 0, 0, 0);
    step(12'h321, 0, 0, 0, 1, 0);
    idle(STR + 3, 12'h321);
    // R1 R5 R6: level modes and unused codes
    phase = "R1 R5 R6 levels";
    for (int k = 0; k < 16; k++)
      step(12'h940, k[0], 1, 1, 1, k[1]);
    phase = "R6 codes 5..15";
    for (int c = 5; c < 16; c++)
      for (int k = 0; k < 3; k++)
        step({c[3:0], c[3:0], c[3:0]}, 1, k[0], k[0], k[0], 1);
    // R10: same source on several LEDs, then mode switched mid-window
    phase = "R10 shared source";
    step(12'h111, 0, 1, 0, 0, 0);
    step(12'h111, 0, 0, 0, 0, 0);
    step(12'h014, 0, 0, 0, 0, 1);
    idle(STR + 2, 12'h104);
    // R10 random mix across all modes
    phase = "R10 random";
    for (int k = 0; k < 600; k++) begin
      logic [NL*4-1:0] m;
      for (int i = 0; i < NL; i++)
        m[i*4 +: 4] = ($urandom_range(0,9) == 0) ? 4'($urandom_range(5,15)) : 4'($urandom_range(0,4));
      if ($urandom_range(0,7) != 0 && k > 0) m = mode;
      step(m, $urandom_range(0,1), $urandom_range(0,3) == 0, $urandom_range(0,3) == 0,
           $urandom_range(0,5) == 0, $urandom_range(0,1));
    end
    @(negedge clk); check_now();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule